// File: doc/BRIEF.md
# I2C Register-Port Slave Controller

This block is the serial control port of a small register bank. It watches the two-wire bus (clock SCL and data SDA) with a faster system clock. It answers only to its own 7-bit device address, and one bit of that address comes from a strap pin. A write transaction first loads an internal byte pointer and then stores data bytes into the register the pointer selects. A read transaction returns the register the pointer selects, most significant bit first.

The pointer byte has two parts. Its top bit turns auto-advance on or off. Its lower seven bits pick one of 128 registers. With auto-advance on, each data byte moves the pointer to the next register, in both directions of transfer. With it off, every byte of a burst touches the same register. The pointer keeps its value from one transaction to the next, so a read with no pointer write returns the register selected last.

The register bank itself sits outside the block. It is reached through an address and write-data bus, a one-cycle write strobe, and a read-data return that must follow the address combinationally. The bus is open-drain: the block only pulls SDA low through an enable output.

Top module: `i2c_regport_slave`

## Requirements
- R1: The slave acknowledges an address byte (pulls SDA low during the ninth clock) when bits 7..2 of the byte are 001000 and bit 1 equals `addr_sel_i`. Bit 0 of the byte is the direction flag, and 1 means read.
- R2: After an address byte that does not match, the slave gives no acknowledge and keeps SDA released. It performs no register write and leaves the pointer unchanged until the next START.
- R3: In a write transaction, the first byte after the address is acknowledged and taken as the pointer. Bit 7 is the auto-advance flag and bits 6..0 are the register address driven on `reg_addr_o`.
- R4: Each later write byte is acknowledged and written to the register at the pointer. With auto-advance set, the pointer then steps by one and wraps from 0x7F to 0x00. With auto-advance clear, the pointer stays.
- R5: `reg_we_o` is a single-cycle pulse, one for each received data byte, raised only while SCL is low.
- R6: After a read address is acknowledged, the slave sends the register at the pointer, MSB first. The pointer keeps its last written value across transactions, and it is 0x01 with auto-advance clear after reset.
- R7: In a read burst where the master acknowledges each byte, auto-advance set returns successive registers. Auto-advance clear returns the same register again.
- R8: When the master does not acknowledge a read byte, the slave releases SDA, does not step the pointer, and waits for STOP or START.
- R9: The slave changes its SDA drive only while SCL is low.
- R10: START (SDA falling while SCL is high) restarts address reception from any state. STOP (SDA rising while SCL is high) ends the transaction, releases SDA and cancels a partly received byte without a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| addr_sel_i | input | 1 | Strap that sets address bit 1 |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| reg_addr_o | output | 7 | Register address (current pointer) |
| reg_wdata_o | output | 8 | Write data for the register bank |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_rdata_i | input | 8 | Read data of the register at `reg_addr_o` |

## Verification
The bench reads right after reset, with no pointer write. A design that reset the pointer wrongly would return the wrong register. It drives addresses that are wrong in the strap bit or in the fixed bits; a loose compare would acknowledge them or write bytes that belong to another device. Read bursts end in a NACK, and the bench checks the pointer afterwards; a design that stepped on the NACK byte would leave the pointer one too far. The bench also writes across address 0x7F, and aborts a byte half-way with STOP. A design with a wide pointer would miss the wrap, and one that kept partial bits would make a spurious write.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam logic [5:0] DEV_ID_HI = 6'b001000;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_PTR,
    ST_WDAT,
    ST_ACK_W,
    ST_TX,
    ST_RACK,
    ST_SKIP
  } i2cs_state_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/i2cs_busmon.sv
module i2cs_busmon #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_s;
  logic scl_p_q, sda_p_q;

  i2cs_sync #(.W(2), .STAGES(STAGES), .RST_VAL(2'b11)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({scl_i, sda_i}),
    .q    ({scl_s, sda_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
    end else begin
      scl_p_q <= scl_s;
      sda_p_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_p_q;
  assign scl_fall = ~scl_s & scl_p_q;
  assign start_ev = scl_s & scl_p_q & sda_p_q & ~sda_s;
  assign stop_ev  = scl_s & scl_p_q & ~sda_p_q & sda_s;
endmodule

// File: rtl/i2cs_ptr.sv
module i2cs_ptr #(
  parameter int AW = 7,
  parameter logic [AW-1:0] RST_ADDR = 7'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW:0]   load_val,
  input  logic          adv,
  output logic [AW-1:0] addr,
  output logic          inc
);
  logic [AW-1:0] addr_q, addr_d;
  logic          inc_q, inc_d;

  always_comb begin
    addr_d = addr_q;
    inc_d  = inc_q;
    if (load) begin
      inc_d  = load_val[AW];
      addr_d = load_val[AW-1:0];
    end else if (adv && inc_q) begin
      addr_d = addr_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= RST_ADDR;
      inc_q  <= 1'b0;
    end else if (load || adv) begin
      addr_q <= addr_d;
      inc_q  <= inc_d;
    end
  end

  assign addr = addr_q;
  assign inc  = inc_q;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_s,
  input  logic              addr_sel,
  input  logic [BYTE_W-1:0] rdata,
  output logic              sda_oe,
  output logic              ptr_load,
  output logic              ptr_adv,
  output logic              reg_we,
  output logic [BYTE_W-1:0] byte_q
);
  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(BYTE_W);

  i2cs_state_e       state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              rw_q, rw_d;
  logic              acked_q, acked_d;
  logic              oe_q, oe_d;
  logic              addr_hit;

  assign addr_hit = (sh_q[BYTE_W-1 -: 6] == DEV_ID_HI) && (sh_q[1] == addr_sel);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    rw_d     = rw_q;
    acked_d  = acked_q;
    oe_d     = oe_q;
    ptr_load = 1'b0;
    ptr_adv  = 1'b0;
    reg_we   = 1'b0;
    if (stop_ev) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_ev) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_PTR, ST_WDAT: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + CW'(1);
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            cnt_d = '0;
            if (state_q == ST_ADDR) begin
              if (addr_hit) begin
                state_d = ST_ACK_A;
                rw_d    = sh_q[0];
                oe_d    = 1'b1;
              end else begin
                state_d = ST_SKIP;
              end
            end else begin
              state_d = ST_ACK_W;
              oe_d    = 1'b1;
              if (state_q == ST_PTR) begin
                ptr_load = 1'b1;
              end else begin
                reg_we  = 1'b1;
                ptr_adv = 1'b1;
              end
            end
          end
        end
        ST_ACK_A: begin
          if (scl_fall) begin
            if (rw_q) begin
              state_d = ST_TX;
              sh_d    = rdata;
              oe_d    = ~rdata[BYTE_W-1];
            end else begin
              state_d = ST_PTR;
              oe_d    = 1'b0;
            end
          end
        end
        ST_ACK_W: begin
          if (scl_fall) begin
            state_d = ST_WDAT;
            oe_d    = 1'b0;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_d = cnt_q + CW'(1);
          end else if (scl_fall) begin
            if (cnt_q == CNT_FULL) begin
              state_d = ST_RACK;
              oe_d    = 1'b0;
              cnt_d   = '0;
            end else begin
              sh_d = {sh_q[BYTE_W-2:0], 1'b0};
              oe_d = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            acked_d = ~sda_s;
            ptr_adv = ~sda_s;
          end else if (scl_fall) begin
            if (acked_q) begin
              state_d = ST_TX;
              sh_d    = rdata;
              oe_d    = ~rdata[BYTE_W-1];
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      acked_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      rw_q    <= rw_d;
      acked_q <= acked_d;
      oe_q    <= oe_d;
    end
  end

  assign sda_oe = oe_q;
  assign byte_q = sh_q;
endmodule

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [BYTE_W-2:0] PTR_RST = 7'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-2:0] reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  localparam int PTR_W = BYTE_W - 1;

  logic [1:0] rst_pipe_q;
  logic       rst_s;
  logic       sda_w, rise_w, fall_w, start_w, stop_w;
  logic       load_w, adv_w, inc_w;
  logic [BYTE_W-1:0] byte_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s = rst_pipe_q[1];

  i2cs_busmon #(.STAGES(SYNC_STAGES)) u_busmon (
    .clk     (clk),
    .rst_n   (rst_s),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .sda_s   (sda_w),
    .scl_rise(rise_w),
    .scl_fall(fall_w),
    .start_ev(start_w),
    .stop_ev (stop_w)
  );

  i2cs_engine u_engine (
    .clk     (clk),
    .rst_n   (rst_s),
    .scl_rise(rise_w),
    .scl_fall(fall_w),
    .start_ev(start_w),
    .stop_ev (stop_w),
    .sda_s   (sda_w),
    .addr_sel(addr_sel_i),
    .rdata   (reg_rdata_i),
    .sda_oe  (sda_oe_o),
    .ptr_load(load_w),
    .ptr_adv (adv_w),
    .reg_we  (reg_we_o),
    .byte_q  (byte_w)
  );

  i2cs_ptr #(.AW(PTR_W), .RST_ADDR(PTR_RST)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_s),
    .load    (load_w),
    .load_val(byte_w),
    .adv     (adv_w),
    .addr    (reg_addr_o),
    .inc     (inc_w)
  );

  assign reg_wdata_o = byte_w;
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       reg_we,
  input logic [6:0] reg_addr,
  input logic       stop_ev,
  input logic       ptr_load,
  input logic       ptr_inc
);
  p_oe_moves_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  p_we_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  p_we_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !scl_i);

  p_stop_releases_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  p_noinc_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_inc && !ptr_load) |=> $stable(reg_addr));
endmodule

bind i2c_regport_slave i2cs_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_s),
  .scl_i   (scl_i),
  .sda_oe  (sda_oe_o),
  .reg_we  (reg_we_o),
  .reg_addr(reg_addr_o),
  .stop_ev (stop_w),
  .ptr_load(load_w),
  .ptr_inc (inc_w)
);

// File: tb/i2c_regport_slave_tb.sv
`timescale 1ns/1ps
module i2c_regport_slave_tb_top;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_oe = 1'b0;
  logic sel = 1'b1;
  logic dut_oe, we;
  logic [6:0] raddr;
  logic [7:0] wdata, rdata;
  wire  sda_bus;
  logic [7:0] regs [128];

  int n_chk = 0;
  int n_err = 0;
  int we_cnt = 0;
  int we_bad = 0;
  int edge_bad = 0;
  logic we_q = 1'b0;
  logic oe_q = 1'b0;

  always #4 clk = ~clk;

  assign sda_bus = ~(m_oe | dut_oe);
  assign rdata = regs[raddr];

  i2c_regport_slave dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_bus),
    .addr_sel_i (sel),
    .sda_oe_o   (dut_oe),
    .reg_addr_o (raddr),
    .reg_wdata_o(wdata),
    .reg_we_o   (we),
    .reg_rdata_i(rdata)
  );

  function automatic logic [7:0] init_val(int i);
    return 8'((i * 7) + 8'h31);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) regs[i] <= init_val(i);
    end else if (we) begin
      regs[raddr] <= wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (we && we_q) we_bad++;
      if (we && m_scl) we_bad++;
      if (we) we_cnt++;
      if (dut_oe != oe_q && m_scl) edge_bad++;
    end
    we_q <= we;
    oe_q <= dut_oe;
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic m_start();
    m_oe = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_oe = 1'b1; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic m_stop();
    m_oe = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_oe = 1'b0; tick(Q);
  endtask

  task automatic m_bits(logic [7:0] v, int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_oe = ~v[i]; tick(Q);
      m_scl = 1'b1; tick(2 * Q);
      m_scl = 1'b0; tick(Q);
    end
  endtask

  task automatic m_send(logic [7:0] v, output logic ack);
    m_bits(v, 8);
    m_oe = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    ack = ~sda_bus; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic m_recv(logic nack, output logic [7:0] d);
    m_oe = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      m_scl = 1'b1; tick(Q);
      d[i] = sda_bus; tick(Q);
      m_scl = 1'b0; tick(2 * Q);
    end
    m_oe = ~nack; tick(Q);
    m_scl = 1'b1; tick(2 * Q);
    m_scl = 1'b0; tick(Q);
    m_oe = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R6 reset pointer", int'(raddr), 'h01);
    chk("R10 reset sda released", int'(dut_oe), 0);
    chk("R5 reset no write", int'(we), 0);
  endtask

  task automatic t_read_default();
    logic a; logic [7:0] d;
    m_start();
    m_send(8'h23, a); chk("R1 read address ack", int'(a), 1);
    m_recv(1'b1, d);  chk("R6 default register data", int'(d), int'(init_val(1)));
    @(negedge clk);
    chk("R8 sda released after nack", int'(dut_oe), 0);
    m_stop();
    @(negedge clk);
    chk("R8 pointer not stepped on nack", int'(raddr), 'h01);
  endtask

  task automatic t_mismatch();
    logic a; int w0;
    w0 = we_cnt;
    m_start();
    m_send(8'h20, a); chk("R2 strap bit mismatch no ack", int'(a), 0);
    m_send(8'h85, a); chk("R2 following byte ignored", int'(a), 0);
    m_send(8'h77, a); chk("R2 data byte ignored", int'(a), 0);
    m_stop();
    m_start();
    m_send(8'h32, a); chk("R2 fixed bits mismatch no ack", int'(a), 0);
    m_stop();
    @(negedge clk);
    chk("R2 no write on mismatch", we_cnt - w0, 0);
    chk("R2 pointer untouched", int'(raddr), 'h01);
    sel = 1'b0;
    m_start();
    m_send(8'h20, a); chk("R1 strap low accepts 0x20", int'(a), 1);
    m_stop();
    sel = 1'b1;
  endtask

  task automatic t_write_inc();
    logic a; int w0;
    w0 = we_cnt;
    m_start();
    m_send(8'h22, a); chk("R1 write address ack", int'(a), 1);
    m_send(8'h90, a); chk("R3 pointer byte ack", int'(a), 1);
    @(negedge clk);
    chk("R3 pointer loaded", int'(raddr), 'h10);
    m_send(8'hA1, a); chk("R4 data ack", int'(a), 1);
    m_send(8'hA2, a);
    m_send(8'hA3, a); chk("R4 last data ack", int'(a), 1);
    m_stop();
    @(negedge clk);
    chk("R4 reg 0x10", int'(regs[8'h10]), 'hA1);
    chk("R4 reg 0x11", int'(regs[8'h11]), 'hA2);
    chk("R4 reg 0x12", int'(regs[8'h12]), 'hA3);
    chk("R4 pointer advanced", int'(raddr), 'h13);
    chk("R5 one strobe per byte", we_cnt - w0, 3);
  endtask

  task automatic t_read_inc();
    logic a; logic [7:0] d;
    m_start();
    m_send(8'h22, a);
    m_send(8'h90, a);
    m_start();
    m_send(8'h23, a); chk("R10 repeated start read ack", int'(a), 1);
    m_recv(1'b0, d); chk("R7 burst byte 0", int'(d), 'hA1);
    m_recv(1'b0, d); chk("R7 burst byte 1", int'(d), 'hA2);
    m_recv(1'b1, d); chk("R7 burst byte 2", int'(d), 'hA3);
    m_stop();
    @(negedge clk);
    chk("R8 pointer after nack burst", int'(raddr), 'h12);
  endtask

  task automatic t_write_noinc();
    logic a;
    m_start();
    m_send(8'h22, a);
    m_send(8'h05, a);
    m_send(8'h11, a);
    m_send(8'h22, a); chk("R4 second byte ack", int'(a), 1);
    m_stop();
    @(negedge clk);
    chk("R4 same reg overwritten", int'(regs[5]), 'h22);
    chk("R4 next reg untouched", int'(regs[6]), int'(init_val(6)));
    chk("R4 pointer held", int'(raddr), 'h05);
  endtask

  task automatic t_read_noinc();
    logic a; logic [7:0] d;
    m_start();
    m_send(8'h23, a); chk("R6 read without pointer write ack", int'(a), 1);
    m_recv(1'b0, d); chk("R6 pointer persisted", int'(d), 'h22);
    m_recv(1'b1, d); chk("R7 no-advance repeats register", int'(d), 'h22);
    m_stop();
    @(negedge clk);
    chk("R7 pointer fixed", int'(raddr), 'h05);
  endtask

  task automatic t_wrap();
    logic a;
    m_start();
    m_send(8'h22, a);
    m_send(8'hFF, a);
    m_send(8'h5A, a);
    m_send(8'h5B, a);
    m_stop();
    @(negedge clk);
    chk("R4 reg 0x7F", int'(regs[8'h7F]), 'h5A);
    chk("R4 wrap to reg 0x00", int'(regs[0]), 'h5B);
    chk("R4 pointer after wrap", int'(raddr), 'h01);
  endtask

  task automatic t_abort();
    logic a; logic [7:0] d; int w0;
    m_start();
    m_send(8'h22, a);
    m_send(8'h03, a);
    w0 = we_cnt;
    m_bits(8'hF0, 4);
    m_stop();
    @(negedge clk);
    chk("R10 partial byte not written", we_cnt - w0, 0);
    m_start();
    m_send(8'h23, a);
    m_recv(1'b1, d); chk("R10 pointer kept after abort", int'(d), int'(init_val(3)));
    m_stop();
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_read_default();
    t_mismatch();
    t_write_inc();
    t_read_inc();
    t_write_noinc();
    t_read_noinc();
    t_wrap();
    t_abort();
    chk("R5 strobe shape", we_bad, 0);
    chk("R9 drive changes with scl low", edge_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule